// File: doc/BRIEF.md
# EPROM Coefficient Boot Loader

At power-up, the first device in a chain of image-filter devices can configure every device in the chain without a host processor. This block is the sequencer that does it. Once reset is released, it reads a byte-wide EPROM and writes each byte into one register of one device.

Each device owns a 128-byte page of the EPROM. Only two parts of the page are loaded: the nine control bytes at the bottom and the 64 coefficient bytes at the top. The bytes in between are skipped.

For every byte, the sequencer does the following:
- It presents the EPROM address and latches the returned byte.
- It drives the target device index, the register address and the data.
- It raises the write strobe and holds it until a reply comes back from the last device in the chain.

With a single device, the reply path is closed inside the block. Each wait for a reply is bounded by a programmable timeout. When the timeout expires, the sequence stops with an error.

The block runs on its own free-running clock, so it does not depend on the pixel clock. When the last coefficient of the last device has been written, it raises a completion flag.

Top module: `bootld_top`

## Requirements
- R1: While reset is low, `rom_addr`, `wr_stb`, `load_done` and `load_err` are all 0. The first strobe after reset is released targets device 0, location 0.
- R2: Within each device, locations are visited in the order 0 to 8 and then 64 to 127. Locations 9 to 63 are never strobed, so each device receives 73 strobes.
- R3: Devices are visited in ascending order from 0 to `cfg_last_dev`.
  - `rom_addr` is {device[3:0], location[6:0]}.
  - `tgt_dev` and `tgt_reg` equal those two fields.
- R4: `wr_data` is the EPROM byte present during the cycle before the strobe rises. It is held for as long as the strobe is high.
- R5: When `cfg_last_dev` is 0, the reply is generated internally and every strobe lasts exactly two cycles. `chain_reply` has no effect in this mode.
- R6: When `cfg_last_dev` is non-zero, `chain_reply` passes through a `SYNC_STAGES`-flop synchronizer.
  - The strobe stays high until the synchronized reply is 1.
  - The next fetch starts only after the synchronized reply has returned to 0.
- R7: `load_done` rises after the reply for location 127 of device `cfg_last_dev` has dropped. It then stays high with no further strobes until reset.
- R8: If the awaited reply level is not seen within `cfg_tmo`+1 cycles of waiting, `load_err` rises. Once set, `load_err` stays high until reset and no further strobes are issued.
- R9: `host_rw` is 0 at all times, which signals a write.
- R10: Asserting reset in the middle of a load aborts it. The next load starts again at device 0, location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running loader clock, independent of the pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low; loading starts after release |
| cfg_last_dev | input | 4 | Index of the last device in the chain (number of devices minus 1) |
| cfg_tmo | input | 8 | Reply timeout limit, in cycles |
| rom_addr | output | 11 | EPROM byte address |
| rom_data | input | 8 | EPROM read data |
| chain_reply | input | 1 | Reply fed back from the last device of a multi-device chain |
| tgt_dev | output | 4 | Index of the device being written |
| tgt_reg | output | 7 | Register address within that device |
| wr_data | output | 8 | Data driven to the registers |
| wr_stb | output | 1 | Write strobe, active high |
| host_rw | output | 1 | Read/write line, held at 0 (write) |
| load_done | output | 1 | Loading finished |
| load_err | output | 1 | Reply timeout; the sequence has stopped |

## Verification
The assertions take for granted three things about the inputs:
- `cfg_last_dev` and `cfg_tmo` change only while reset is held.
- `rom_data` settles within the single fetch cycle after `rom_addr` changes.
- `chain_reply` follows the strobe level, so that a correct design never waits in the gap phase without cause.

The bench keeps within these limits in the following ways:
- It changes the configuration only during reset.
- It models the EPROM as a combinational function of the address.
- It derives `chain_reply` from a delayed copy of `wr_stb`. The only exceptions are two deliberate runs, one with the reply held low and one with it held high, which exercise the timeout.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  localparam int DEV_W     = 4;
  localparam int LOC_W     = 7;
  localparam int DATA_W    = 8;
  localparam int CTL_N     = 9;
  localparam int COEF_BASE = 64;
  localparam int ADDR_W    = DEV_W + LOC_W;
  localparam int LOADS_PER_DEV = CTL_N + ((1 << LOC_W) - COEF_BASE);

  typedef enum logic [2:0] {
    PH_FETCH = 3'd0,
    PH_STRB  = 3'd1,
    PH_GAP   = 3'd2,
    PH_DONE  = 3'd3,
    PH_ERR   = 3'd4
  } ph_e;

  // next location in a page: jump over the unused middle
  function automatic logic [LOC_W-1:0] loc_step(input logic [LOC_W-1:0] l);
    if (l == LOC_W'(CTL_N - 1)) return LOC_W'(COEF_BASE);
    return l + 1'b1;
  endfunction

  function automatic logic loc_last(input logic [LOC_W-1:0] l);
    return l == {LOC_W{1'b1}};
  endfunction
endpackage

// File: rtl/reply_sync.sv
module reply_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_flops
      logic [STAGES-1:0] sh_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_st
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b0;
          else        sh_q[i] <= (i == 0) ? d : sh_q[(i == 0) ? 0 : i-1];
        end
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bootld_loc_ctr.sv
module bootld_loc_ctr
  import bootld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [DEV_W-1:0] dev,
  output logic [LOC_W-1:0] loc,
  output logic             wrap
);
  assign wrap = loc_last(loc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev <= '0;
      loc <= '0;
    end else if (adv) begin
      loc <= loc_step(loc);
      if (wrap) dev <= dev + 1'b1;
    end
  end
endmodule

// File: rtl/bootld_top.sv
module bootld_top
  import bootld_pkg::*;
#(
  parameter int TMO_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  cfg_last_dev,
  input  logic [TMO_W-1:0]  cfg_tmo,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  input  logic              chain_reply,
  output logic [DEV_W-1:0]  tgt_dev,
  output logic [LOC_W-1:0]  tgt_reg,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_stb,
  output logic              host_rw,
  output logic              load_done,
  output logic              load_err
);
  ph_e ph_q, ph_d;
  logic [DATA_W-1:0] data_q;
  logic [TMO_W-1:0]  tmo_q;
  logic stb_echo_q, ext_reply, loc_wrap;
  // named internal events
  logic single_dev, reply_seen, waiting, level_ok, tmo_hit, seq_end, step_adv;

  reply_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(chain_reply), .q(ext_reply));

  bootld_loc_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(step_adv),
    .dev(tgt_dev), .loc(tgt_reg), .wrap(loc_wrap));

  assign single_dev = (cfg_last_dev == '0);
  assign reply_seen = single_dev ? stb_echo_q : ext_reply;
  assign waiting    = (ph_q == PH_STRB) || (ph_q == PH_GAP);
  assign level_ok   = (ph_q == PH_STRB) ? reply_seen : !reply_seen;
  assign tmo_hit    = waiting && !level_ok && (tmo_q == cfg_tmo);
  assign seq_end    = loc_wrap && (tgt_dev == cfg_last_dev);
  assign step_adv   = (ph_q == PH_GAP) && !reply_seen && !seq_end;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_FETCH: ph_d = PH_STRB;
      PH_STRB:  if (reply_seen) ph_d = PH_GAP;
                else if (tmo_hit) ph_d = PH_ERR;
      PH_GAP:   if (!reply_seen) ph_d = seq_end ? PH_DONE : PH_FETCH;
                else if (tmo_hit) ph_d = PH_ERR;
      default:  ph_d = ph_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_FETCH;
      data_q     <= '0;
      tmo_q      <= '0;
      stb_echo_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      stb_echo_q <= wr_stb;
      if (ph_q == PH_FETCH) data_q <= rom_data;
      if ((ph_q == PH_FETCH) || ((ph_q == PH_STRB) && reply_seen))
        tmo_q <= '0;
      else if (waiting && !level_ok && !tmo_hit)
        tmo_q <= tmo_q + 1'b1;
    end
  end

  assign rom_addr  = {tgt_dev, tgt_reg};
  assign wr_data   = data_q;
  assign wr_stb    = (ph_q == PH_STRB);
  assign host_rw   = 1'b0;
  assign load_done = (ph_q == PH_DONE);
  assign load_err  = (ph_q == PH_ERR);
endmodule

// File: rtl/bootld_chk.sv
module bootld_chk
  import bootld_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DEV_W-1:0]  cfg_last_dev,
  input logic [DATA_W-1:0] rom_data,
  input logic [DEV_W-1:0]  tgt_dev,
  input logic [LOC_W-1:0]  tgt_reg,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_stb,
  input logic              load_done,
  input logic              load_err,
  input logic              reply_seen,
  input logic              tmo_hit
);
  // R2
  skip_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (tgt_reg < LOC_W'(CTL_N)) || (tgt_reg >= LOC_W'(COEF_BASE)));
  // R3
  dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> tgt_dev <= cfg_last_dev);
  // R4
  data_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> wr_data == $past(rom_data));
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> $stable(wr_data));
  // R5
  single_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_last_dev == '0 && wr_stb && $past(wr_stb)) |=> !wr_stb);
  // R6
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !reply_seen && !tmo_hit) |=> wr_stb);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done && !wr_stb);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err && !wr_stb);
  // R8
  tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> load_err);
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && load_err));
endmodule

bind bootld_top bootld_chk u_chk (.*);

// File: tb/sim_bootld_top.sv
module sim_bootld_top;
  localparam int SYNC = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_last_dev = '0;
  logic [7:0] cfg_tmo = 8'd40;
  logic [10:0] rom_addr;
  logic [7:0] rom_data, wr_data;
  logic chain_reply = 1'b0;
  logic [3:0] tgt_dev;
  logic [6:0] tgt_reg;
  logic wr_stb, host_rw, load_done, load_err;

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_f(input int a);
    return 8'((a * 7) + ((a >> 7) * 13) + 5);
  endfunction
  assign rom_data = rom_f(int'(rom_addr));

  bootld_top #(.TMO_W(8), .SYNC_STAGES(SYNC)) u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int reply_mode = 0;   // 0 delayed echo, 1 dead, 2 stuck high, 3 noise
  int reply_dly  = 1;
  logic [15:0] hist = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // chain model: last device echoes the strobe after a delay
  always @(negedge clk) begin
    hist = {hist[14:0], wr_stb};
    case (reply_mode)
      0: chain_reply = hist[reply_dly];
      1: chain_reply = 1'b0;
      2: chain_reply = 1'b1;
      default: chain_reply = cyc[1];
    endcase
  end

  // behavioural reference model
  int m_ph = 0, m_dev = 0, m_loc = 0, m_tmo = 0, m_data = 0, m_pstb = 0;
  int syn[SYNC];
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_dev = 0; m_loc = 0; m_tmo = 0; m_data = 0; m_pstb = 0;
      foreach (syn[i]) syn[i] = 0;
    end else begin
      automatic int rs = (cfg_last_dev == 0) ? m_pstb : syn[SYNC-1];
      automatic int old = m_ph;
      for (int i = SYNC-1; i > 0; i--) syn[i] = syn[i-1];
      syn[0] = chain_reply;
      m_pstb = (old == 1);
      if (old == 0) begin
        m_data = rom_f(m_dev * 128 + m_loc); m_tmo = 0; m_ph = 1;
      end else if (old == 1) begin
        if (rs != 0) begin m_ph = 2; m_tmo = 0; end
        else if (m_tmo == int'(cfg_tmo)) m_ph = 4;
        else m_tmo++;
      end else if (old == 2) begin
        if (rs == 0) begin
          if (m_loc == 127 && m_dev == int'(cfg_last_dev)) m_ph = 3;
          else begin
            if (m_loc == 127) begin m_loc = 0; m_dev++; end
            else if (m_loc == 8) m_loc = 64;
            else m_loc++;
            m_ph = 0;
          end
        end else if (m_tmo == int'(cfg_tmo)) m_ph = 4;
        else m_tmo++;
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  int n_stb = 0, n_mid = 0, first_loc = -1;
  logic prev_stb = 1'b0;
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      automatic string stag = (cfg_last_dev == 0) ? "R5" : "R6";
      check(wr_stb == (m_ph == 1), stag, wr_stb, m_ph == 1);
      check(rom_addr == 11'(m_dev * 128 + m_loc), "R3", rom_addr, m_dev * 128 + m_loc);
      check(tgt_dev == 4'(m_dev) && tgt_reg == 7'(m_loc), "R3", {tgt_dev, tgt_reg}, m_dev * 128 + m_loc);
      if (wr_stb) check(wr_data == 8'(m_data), "R4", wr_data, m_data);
      check(load_done == (m_ph == 3), "R7", load_done, m_ph == 3);
      check(load_err == (m_ph == 4), "R8", load_err, m_ph == 4);
      check(host_rw == 1'b0, "R9", host_rw, 0);
      if (wr_stb && !prev_stb) begin
        if (first_loc < 0) first_loc = int'(rom_addr);
        n_stb++;
        if (tgt_reg >= 9 && tgt_reg < 64) n_mid++;
      end
    end
    prev_stb = wr_stb;
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<=150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic start(input int last, input int tmo, input int mode, input int dly);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_last_dev = 4'(last); cfg_tmo = 8'(tmo);
    reply_mode = mode; reply_dly = dly;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rom_addr == 0 && !wr_stb && !load_done && !load_err, "R1",
          {rom_addr, wr_stb, load_done, load_err}, 0);
    n_stb = 0; n_mid = 0; first_loc = -1;
    rst_n = 1'b1;
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit && !load_done && !load_err; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    // single device, chain input toggling but ignored
    start(0, 40, 3, 1);
    wait_end(2000);
    check(load_done, "R7", load_done, 1);
    check(n_stb == 73, "R7", n_stb, 73);
    check(n_mid == 0, "R2", n_mid, 0);
    check(first_loc == 0, "R1", first_loc, 0);

    // three devices, slow reply
    start(2, 40, 0, 4);
    wait_end(20000);
    check(load_done, "R7", load_done, 1);
    check(n_stb == 219, "R6", n_stb, 219);
    check(n_mid == 0, "R2", n_mid, 0);

    // full chain of 16 devices
    start(15, 40, 0, 1);
    wait_end(40000);
    check(load_done && !load_err, "R7", load_done, 1);
    check(n_stb == 16 * 73, "R3", n_stb, 16 * 73);

    // reset in the middle of a load restarts at the beginning
    start(3, 40, 0, 2);
    repeat (900) @(negedge clk);
    check(n_stb > 73, "R10", n_stb, 74);
    start(3, 40, 0, 2);
    wait_end(40000);
    check(first_loc == 0, "R10", first_loc, 0);
    check(n_stb == 4 * 73, "R10", n_stb, 4 * 73);

    // reply never arrives
    start(1, 5, 1, 1);
    wait_end(200);
    check(load_err && !load_done, "R8", load_err, 1);
    check(n_stb == 1, "R8", n_stb, 1);

    // reply stuck high
    start(1, 3, 2, 1);
    wait_end(200);
    check(load_err, "R8", load_err, 1);
    check(!wr_stb, "R8", wr_stb, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule